// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker

This block sits beside a DDR SDRAM command bus on the controller side and follows, one bank at a time, what the memory is doing. Every clock it decodes the active-low select and strobe lines together with the bank address and the auto-precharge address bit. It then moves each addressed bank through its row, burst, recovery and precharge phases. Each timed phase is held for a parameterised number of clock cycles by one down-counter per bank.

The block only observes the bus. It drives nothing onto it. It publishes a 4-bit state code for every bank and raises a flag one cycle after any command that the present state of a bank (or of the whole device) forbids. A forbidden command is treated as if it had never been issued, so the tracked state stays consistent with what a correctly behaving memory would hold. Burst length, CAS latency and all timing values are parameters. A burst occupies BL/2 clock cycles because data moves on both clock edges.

Top module: `ddr_bank_tracker`

## Requirements
- R1: While reset is held low at a clock edge, every bank goes to state code 0 (Idle) and the illegal flag goes low.
- R2: Decode uses active-low pins. cs_n=1 is deselect. With cs_n=0, {ras_n,cas_n,we_n} = 111 is no-op, 110 is burst stop, 101 is read, 100 is write, 011 is activate, 010 is precharge, 001 is refresh and 000 is mode set. Deselect and no-op are never flagged and change no bank.
- R3: An activate to an Idle bank puts it in code 1 (Activating) from the cycle after the command, for T_RCD cycles, and then in code 2 (Active). An activate to a bank that is not Idle is illegal.
- R4: A read with a10=0 is legal only in Active or Reading. It gives code 3 (Reading) for CL+BL/2 cycles, and then Active.
- R5: A read with a10=1 gives code 4 (Read with auto-precharge) for CL+BL/2 cycles, then code 8 (Precharging) for T_RP cycles, then Idle.
- R6: A write with a10=0 is legal in Active, Writing or Write recovering. It gives code 5 (Writing) for BL/2 cycles, then code 7 (Write recovering) for T_WR cycles, then Active.
- R7: A write with a10=1 gives code 6 (Write with auto-precharge) for BL/2+T_WR cycles, then Precharging for T_RP cycles, then Idle.
- R8: A burst stop is illegal while any bank is in code 4 or code 6. Read, write, activate and precharge to such a bank are illegal. Commands to other banks stay legal.
- R9: A write to a bank in Reading is illegal. A burst stop returns every Reading bank to Active.
- R10: A precharge with a10=0 acts on bank ba, and one with a10=1 acts on all banks. An Active or Reading bank goes to Precharging for T_RP cycles and then to Idle. An Idle bank stays Idle. A precharge that reaches a bank in any other state is illegal.
- R11: Refresh and mode set are legal only when all banks are Idle. Refresh puts every bank in code 9 (Refreshing) for T_RFC cycles, and then Idle.
- R12: The illegal flag is high for the one cycle after an illegal command. An illegal command changes no bank's state beyond the normal expiry of its running timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select bit |
| bank_state | output | NUM_BANKS*4 | State code of bank i in bits [4i+3:4i] |
| cmd_illegal | output | 1 | High the cycle after a forbidden command |

## Verification
The tracker is exercised with command sequences that each probe one phase boundary. Samples are taken both on the last cycle of a timed state and on the first cycle after it, which separates an off-by-one timer from a correct one. Read-then-write pairs are sent with and without an intervening burst stop, which separates the write-after-read rule from plain write legality. Forbidden commands are sent into auto-precharge and refresh windows alongside a legal command to another bank, which shows that a veto is per bank and that a vetoed command leaves the state untouched. Precharge is sent both to one bank and to all banks, with an Idle bank included, which separates the bank decode from the all-bank path.

// File: rtl/ddr_trk_pkg.sv
// Shared types for the DDR bank tracker.
// Assumes 4-bit state codes whose numeric values are visible at the top ports.
package ddr_trk_pkg;

    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        BK_IDLE        = 4'd0,
        BK_ACTIVATING  = 4'd1,
        BK_ACTIVE      = 4'd2,
        BK_READING     = 4'd3,
        BK_READ_AP     = 4'd4,
        BK_WRITING     = 4'd5,
        BK_WRITE_AP    = 4'd6,
        BK_WRITE_REC   = 4'd7,
        BK_PRECHARGING = 4'd8,
        BK_REFRESHING  = 4'd9
    } bank_state_e;

    typedef enum logic [3:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_BST,
        CMD_READ,
        CMD_WRITE,
        CMD_ACT,
        CMD_PRE,
        CMD_REF,
        CMD_MODE
    } cmd_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
// Combinational decode of the active-low command pins into a command type.
// Assumes the pins are already synchronous to clk; no state is kept.
module ddr_cmd_decode
    import ddr_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Map the pin pattern to a command; chip select high overrides everything.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b110:  cmd = CMD_BST;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_MODE;
            endcase
        end
    end

endmodule

// File: rtl/ddr_bank_fsm.sv
// One bank's state machine with a single down-counter for its timed phases.
// It raises an objection when the current command is illegal for this bank.
// It applies a command only when the top grants commit, which means no bank objected.
// Assumes every duration parameter is at least 1.
module ddr_bank_fsm
    import ddr_trk_pkg::*;
#(
    parameter int BANK_IDX = 0,
    parameter int BA_W     = 2,
    parameter int CNT_W    = 4,
    parameter int T_RCD    = 3,
    parameter int T_RP     = 3,
    parameter int T_RFC    = 8,
    parameter int T_WR     = 2,
    parameter int RD_LEN   = 5,
    parameter int WR_LEN   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  cmd_e            cmd,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    input  logic            commit,
    output bank_state_e     state_o,
    output logic            object_o
);

    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_WR  = CNT_W'(T_WR - 1);
    localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] LD_WB  = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] LD_WAP = CNT_W'(WR_LEN + T_WR - 1);

    bank_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             hit, pre_hit, timed;

    // Address match for bank commands and for single or all-bank precharge.
    always_comb begin
        hit     = (ba == BA_W'(BANK_IDX));
        pre_hit = hit || a10;
        timed   = (state_q != BK_IDLE) && (state_q != BK_ACTIVE);
    end

    // Legality of the present command against this bank's state.
    always_comb begin
        object_o = 1'b0;
        case (cmd)
            CMD_ACT:   object_o = hit && (state_q != BK_IDLE);
            CMD_READ:  object_o = hit && !(state_q == BK_ACTIVE || state_q == BK_READING);
            CMD_WRITE: object_o = hit && !(state_q == BK_ACTIVE || state_q == BK_WRITING ||
                                           state_q == BK_WRITE_REC);
            CMD_PRE:   object_o = pre_hit && !(state_q == BK_IDLE || state_q == BK_ACTIVE ||
                                               state_q == BK_READING);
            CMD_BST:   object_o = (state_q == BK_READ_AP) || (state_q == BK_WRITE_AP);
            CMD_REF,
            CMD_MODE:  object_o = (state_q != BK_IDLE);
            default:   object_o = 1'b0;
        endcase
    end

    // Next state: an accepted command wins over timer expiry.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (commit && hit && cmd == CMD_ACT) begin
            state_d = BK_ACTIVATING;
            cnt_d   = LD_RCD;
        end else if (commit && hit && cmd == CMD_READ) begin
            state_d = a10 ? BK_READ_AP : BK_READING;
            cnt_d   = LD_RD;
        end else if (commit && hit && cmd == CMD_WRITE) begin
            state_d = a10 ? BK_WRITE_AP : BK_WRITING;
            cnt_d   = a10 ? LD_WAP : LD_WB;
        end else if (commit && cmd == CMD_BST && state_q == BK_READING) begin
            state_d = BK_ACTIVE;
            cnt_d   = '0;
        end else if (commit && pre_hit && cmd == CMD_PRE && state_q != BK_IDLE) begin
            state_d = BK_PRECHARGING;
            cnt_d   = LD_RP;
        end else if (commit && cmd == CMD_REF) begin
            state_d = BK_REFRESHING;
            cnt_d   = LD_RFC;
        end else if (timed) begin
            if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end else begin
                case (state_q)
                    BK_ACTIVATING: state_d = BK_ACTIVE;
                    BK_READING:    state_d = BK_ACTIVE;
                    BK_WRITE_REC:  state_d = BK_ACTIVE;
                    BK_WRITING: begin
                        state_d = BK_WRITE_REC;
                        cnt_d   = LD_WR;
                    end
                    BK_READ_AP,
                    BK_WRITE_AP: begin
                        state_d = BK_PRECHARGING;
                        cnt_d   = LD_RP;
                    end
                    default:       state_d = BK_IDLE;
                endcase
            end
        end
    end

    // State and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state_o = state_q;

    AST_ACT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_ACTIVATING && $past(state_q) != BK_ACTIVATING) |-> $past(state_q) == BK_IDLE); // R3
    AST_RAP_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == BK_READ_AP && state_q != BK_READ_AP) |-> state_q == BK_PRECHARGING); // R5
    AST_WAP_TO_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == BK_WRITE_AP && state_q != BK_WRITE_AP) |-> state_q == BK_PRECHARGING); // R7
    AST_PRE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == BK_PRECHARGING && state_q != BK_PRECHARGING) |-> state_q == BK_IDLE); // R10
    AST_WR_TO_REC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == BK_WRITING && state_q == BK_ACTIVE) |-> 1'b0); // R6

endmodule

// File: rtl/ddr_bank_tracker.sv
// Top of the DDR bank tracker: decodes commands, runs one FSM per bank,
// vetoes the whole command if any bank objects and registers the illegal flag.
// Assumes the command pins are sampled on the rising clock edge.
module ddr_bank_tracker
    import ddr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BL        = 4,
    parameter int CL        = 3,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 8,
    parameter int T_WR      = 2,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [BA_W-1:0]              ba,
    input  logic                         a10,
    output logic [NUM_BANKS*STATE_W-1:0] bank_state,
    output logic                         cmd_illegal
);

    localparam int RD_LEN  = CL + BL / 2;
    localparam int WR_LEN  = BL / 2;
    localparam int WAP_LEN = WR_LEN + T_WR;
    localparam int MAX_A   = (RD_LEN > WAP_LEN) ? RD_LEN : WAP_LEN;
    localparam int MAX_B   = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T   = (MAX_C > T_RFC) ? MAX_C : T_RFC;
    localparam int CNT_W   = $clog2(MAX_T + 1);

    cmd_e                 cmd_dec;
    logic [NUM_BANKS-1:0] obj_vec;
    logic [NUM_BANKS-1:0] ref_vec;
    logic                 any_obj;
    logic                 commit;
    logic                 illegal_q;

    ddr_cmd_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd_dec)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_state_e st;

        ddr_bank_fsm #(
            .BANK_IDX (b),
            .BA_W     (BA_W),
            .CNT_W    (CNT_W),
            .T_RCD    (T_RCD),
            .T_RP     (T_RP),
            .T_RFC    (T_RFC),
            .T_WR     (T_WR),
            .RD_LEN   (RD_LEN),
            .WR_LEN   (WR_LEN)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd_dec),
            .ba       (ba),
            .a10      (a10),
            .commit   (commit),
            .state_o  (st),
            .object_o (obj_vec[b])
        );

        assign bank_state[b*STATE_W +: STATE_W] = st;
        assign ref_vec[b] = (st == BK_REFRESHING);
    end

    // Global veto: any bank's objection blocks the command for all banks.
    always_comb begin
        any_obj = |obj_vec;
        commit  = !any_obj;
    end

    // Illegal flag follows the offending command by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= any_obj;
        end
    end

    assign cmd_illegal = illegal_q;

    AST_REF_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ref_vec) |-> (&ref_vec)); // R11
    AST_FLAG_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_illegal |-> ($past(cmd_dec) != CMD_DESEL && $past(cmd_dec) != CMD_NOP)); // R2
    AST_VETO_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(any_obj) && $past(bank_state[STATE_W-1:0]) == BK_IDLE)
            |-> bank_state[STATE_W-1:0] == BK_IDLE); // R12

endmodule

// File: tb/ddr_bank_tracker_tb.sv
module ddr_bank_tracker_tb;

    localparam int NB = 4, BL = 4, CL = 3, T_RCD = 3, T_RP = 3, T_RFC = 8, T_WR = 2;
    localparam int RD_LEN = CL + BL / 2;
    localparam int WR_LEN = BL / 2;
    localparam int WAP_LEN = WR_LEN + T_WR;
    localparam logic [2:0] P_NOP = 3'b111, P_BST = 3'b110, P_RD = 3'b101, P_WR = 3'b100;
    localparam logic [2:0] P_ACT = 3'b011, P_PRE = 3'b010, P_REF = 3'b001;

    logic clk = 1'b0;
    logic rst_n, cs_n, ras_n, cas_n, we_n, a10;
    logic [1:0] ba;
    logic [NB*4-1:0] bank_state;
    logic cmd_illegal;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ddr_bank_tracker #(
        .NUM_BANKS (NB), .BL (BL), .CL (CL), .T_RCD (T_RCD),
        .T_RP (T_RP), .T_RFC (T_RFC), .T_WR (T_WR)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n),
        .we_n (we_n), .ba (ba), .a10 (a10), .bank_state (bank_state),
        .cmd_illegal (cmd_illegal)
    );

    function automatic int bst(input int b);
        return int'(bank_state[b*4 +: 4]);
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic pins_nop();
        cs_n = 1'b0; {ras_n, cas_n, we_n} = P_NOP; ba = 2'd0; a10 = 1'b0;
    endtask

    // Issue one command on the coming edge; returns at the next negedge.
    task automatic send(input logic [2:0] p, input int b, input logic a);
        cs_n = 1'b0; {ras_n, cas_n, we_n} = p; ba = 2'(b); a10 = a;
        @(negedge clk);
        pins_nop();
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; pins_nop();
        idle(5);
        rst_n = 1'b1;
        idle(1);
        for (int b = 0; b < NB; b++) chk("R1 bank idle after reset", bst(b), 0);
        chk("R1 flag low after reset", int'(cmd_illegal), 0);
    endtask

    task automatic t_decode();
        cs_n = 1'b1; {ras_n, cas_n, we_n} = P_ACT; ba = 2'd0; a10 = 1'b0;
        @(negedge clk);
        pins_nop();
        chk("R2 deselect masks activate", bst(0), 0);
        chk("R2 deselect not flagged", int'(cmd_illegal), 0);
        send(P_NOP, 0, 1'b0);
        chk("R2 nop not flagged", int'(cmd_illegal), 0);
    endtask

    task automatic t_activate();
        send(P_ACT, 0, 1'b0);
        chk("R3 activating first cycle", bst(0), 1);
        idle(T_RCD - 1);
        chk("R3 activating last cycle", bst(0), 1);
        idle(1);
        chk("R3 active after tRCD", bst(0), 2);
        send(P_ACT, 0, 1'b0);
        chk("R3 activate on active flagged", int'(cmd_illegal), 1);
        chk("R12 illegal activate keeps state", bst(0), 2);
        idle(1);
        chk("R12 flag lasts one cycle", int'(cmd_illegal), 0);
    endtask

    task automatic t_read();
        send(P_RD, 0, 1'b0);
        chk("R4 reading first cycle", bst(0), 3);
        idle(RD_LEN - 1);
        chk("R4 reading last cycle", bst(0), 3);
        idle(1);
        chk("R4 active after burst", bst(0), 2);
    endtask

    task automatic t_write();
        send(P_WR, 0, 1'b0);
        chk("R6 writing first cycle", bst(0), 5);
        idle(WR_LEN - 1);
        chk("R6 writing last cycle", bst(0), 5);
        idle(1);
        chk("R6 write recovering", bst(0), 7);
        idle(T_WR - 1);
        chk("R6 recovering last cycle", bst(0), 7);
        idle(1);
        chk("R6 active after tWR", bst(0), 2);
    endtask

    task automatic t_read_then_write();
        send(P_RD, 0, 1'b0);
        send(P_WR, 0, 1'b0);
        chk("R9 write over read flagged", int'(cmd_illegal), 1);
        chk("R9 bank still reading", bst(0), 3);
        send(P_BST, 0, 1'b0);
        chk("R9 burst stop legal", int'(cmd_illegal), 0);
        chk("R9 burst stop returns active", bst(0), 2);
        send(P_WR, 0, 1'b0);
        chk("R9 write after stop legal", int'(cmd_illegal), 0);
        chk("R9 write after stop writing", bst(0), 5);
        idle(WAP_LEN);
        chk("R9 back to active", bst(0), 2);
    endtask

    task automatic t_write_ap();
        send(P_ACT, 1, 1'b0);
        idle(T_RCD);
        send(P_WR, 1, 1'b1);
        chk("R7 write auto-precharge state", bst(1), 6);
        send(P_RD, 1, 1'b0);
        chk("R8 read during write-ap flagged", int'(cmd_illegal), 1);
        send(P_BST, 0, 1'b0);
        chk("R8 burst stop during write-ap flagged", int'(cmd_illegal), 1);
        send(P_ACT, 3, 1'b0);
        chk("R8 other bank activate legal", int'(cmd_illegal), 0);
        chk("R8 other bank activating", bst(3), 1);
        idle(WAP_LEN - 4);
        chk("R7 write-ap last cycle", bst(1), 6);
        idle(1);
        chk("R7 precharging after write-ap", bst(1), 8);
        idle(T_RP - 1);
        chk("R7 precharging last cycle", bst(1), 8);
        idle(1);
        chk("R7 idle after precharge", bst(1), 0);
    endtask

    task automatic t_read_ap();
        idle(T_RCD);
        send(P_RD, 3, 1'b1);
        chk("R5 read auto-precharge state", bst(3), 4);
        send(P_PRE, 3, 1'b0);
        chk("R8 precharge during read-ap flagged", int'(cmd_illegal), 1);
        chk("R8 read-ap kept", bst(3), 4);
        idle(RD_LEN - 2);
        chk("R5 read-ap last cycle", bst(3), 4);
        idle(1);
        chk("R5 precharging after read-ap", bst(3), 8);
        idle(T_RP);
        chk("R5 idle after precharge", bst(3), 0);
    endtask

    task automatic t_precharge();
        send(P_ACT, 2, 1'b0);
        idle(T_RCD);
        send(P_PRE, 0, 1'b0);
        chk("R10 single precharge target", bst(0), 8);
        chk("R10 single precharge spares other", bst(2), 2);
        idle(T_RP);
        chk("R10 idle after tRP", bst(0), 0);
        send(P_PRE, 0, 1'b1);
        chk("R10 all-bank precharge legal", int'(cmd_illegal), 0);
        chk("R10 all-bank precharge active bank", bst(2), 8);
        chk("R10 all-bank precharge idle bank", bst(0), 0);
        idle(T_RP);
        chk("R10 all-bank idle after tRP", bst(2), 0);
    endtask

    task automatic t_refresh();
        send(P_ACT, 1, 1'b0);
        idle(T_RCD);
        send(P_REF, 0, 1'b0);
        chk("R11 refresh with active bank flagged", int'(cmd_illegal), 1);
        chk("R11 active bank untouched", bst(1), 2);
        send(P_PRE, 1, 1'b0);
        idle(T_RP);
        send(P_REF, 0, 1'b0);
        for (int b = 0; b < NB; b++) chk("R11 refreshing", bst(b), 9);
        send(P_ACT, 0, 1'b0);
        chk("R11 activate during refresh flagged", int'(cmd_illegal), 1);
        chk("R11 still refreshing", bst(0), 9);
        idle(T_RFC - 2);
        chk("R11 refresh last cycle", bst(2), 9);
        idle(1);
        for (int b = 0; b < NB; b++) chk("R11 idle after tRFC", bst(b), 0);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_activate();
        t_read();
        t_write();
        t_read_then_write();
        t_write_ap();
        t_read_ap();
        t_precharge();
        t_refresh();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule